// File: doc/BRIEF.md
# External Bus Release Arbiter

This block hands the external memory bus to an outside DMA master when that master asks for it, and gives it back to the internal bus sequencer afterwards. It sits between the sequencer and the pad drivers. The outside master pulls an active-low request line. The block waits for any bus cycle that is still running to finish, including one stretched by the wait input. It then drives the strobe lines to their inactive (high) level, turns off the pad output buffers and switches in pull-ups where a pin needs one. Only after all of that does it answer with an active-low acknowledge. While the bus is away, the internal master is held in a stall. The rest of the chip, for example the watchdog, keeps running.

The controlled pads are grouped into eleven pin groups. Each group has a mode bit from the port configuration. A group in bus mode takes part in the release. A group in general-purpose port mode is left alone. The third chip select normally carries a programmable pull-down. During release that pull-down is replaced by a pull-up.

The state machine has five states:
- `ST_IDLE`: the internal master owns the bus.
- `ST_WAIT_END`: a request is seen while a cycle is running.
- `ST_DRIVE_INACT`: the strobes are driven high.
- `ST_FLOATED`: the buffers are off and acknowledge may be low.
- `ST_RESTORE`: the buffers are back on, with the strobes still forced high.

The transitions are:
- T1 `ST_IDLE`→`ST_WAIT_END`: request and cycle running, or wait active.
- T2 `ST_IDLE`→`ST_DRIVE_INACT`: request, no cycle and no wait.
- T3 `ST_WAIT_END`→`ST_DRIVE_INACT`: the cycle has ended and wait is inactive.
- T4 `ST_WAIT_END`→`ST_IDLE`: the request is withdrawn.
- T5 `ST_DRIVE_INACT`→`ST_FLOATED`: after the drive interval.
- T6 `ST_FLOATED`→`ST_RESTORE`: the request is gone and acknowledge is already high.
- T7 `ST_RESTORE`→`ST_IDLE`: after the drive interval.

Top module: `busrel_arbiter`

## Requirements
- R1: The request input passes through a two-stage synchroniser. A request that becomes low before clock edge k changes no output until after edge k+2, and the block leaves `ST_IDLE` at edge k+2.
- R2: While `cycle_active` is 1 or `wait_n` is 0, a request holds the block in `ST_WAIT_END`. In that state stall is 1 and no pin control changes. The block moves to `ST_DRIVE_INACT` at the first edge where `cycle_active` is 0 and `wait_n` is 1.
- R3: In `ST_DRIVE_INACT`, for exactly `DRIVE_CYCLES` cycles, the strobe groups in bus mode are forced high with their buffers on. The strobe groups are bits 3 (read), 4 (write), 5 (high write), 6 (read/write) and 7 (row strobe), mask 0x0F8.
- R4: In `ST_FLOATED`, every group in bus mode has its buffer off and no forced value. Pull-ups are on for bits 2 (upper address), 5, 6, 7, 8, 9 and 10 (chip selects 0 to 2), mask 0x7E4. Bits 0 (address/data) and 1 (lower address) float with no pull, and so do bits 3 and 4.
- R5: Acknowledge goes low one cycle after the buffers turn off. It is low only while the block is in `ST_FLOATED` with the request held.
- R6: After the request is removed, acknowledge goes high first. One cycle later the buffers are back on with the strobes forced high for `DRIVE_CYCLES` cycles (`ST_RESTORE`), and then the block is back in `ST_IDLE`.
- R7: `core_stall` is 1 in every state except `ST_IDLE`.
- R8: A group whose mode bit is 0 (port mode) never has float, force or pull-up set.
- R9: `cs2_pull_dn` follows `cs2_pd_cfg`, except when the bus-mode third chip select is pulled up during release; then it is 0.
- R10: A request withdrawn while in `ST_WAIT_END` returns the block to `ST_IDLE`, and acknowledge never goes low.
- R11: After reset: acknowledge is high, stall is 0, and float, force and pull-up are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| wait_n | input | 1 | Active-low wait request for the current bus cycle |
| cycle_active | input | 1 | Sequencer has a bus cycle in progress |
| grp_bus | input | 11 | Per pin group: 1 = bus function, 0 = general-purpose port |
| cs2_pd_cfg | input | 1 | Programmed pull-down for the third chip select |
| bus_ack_n | output | 1 | Active-low bus acknowledge |
| core_stall | output | 1 | Holds the internal master off the bus |
| grp_float | output | 11 | Per group: output buffer off |
| grp_force_hi | output | 11 | Per group: drive a forced high level |
| grp_pull_up | output | 11 | Per group: internal pull-up enabled |
| cs2_pull_dn | output | 1 | Pull-down enable for the third chip select |

## Verification
Some properties are checked on every cycle:
- acknowledge is low only in the floated state;
- acknowledge never falls in the same cycle that the buffers turn off;
- the restore state is entered only with acknowledge high;
- the float and force controls never overlap;
- a stretched cycle is never cut short;
- port-mode groups stay untouched;
- the third chip select never has its pull-up and pull-down on together.

The bench scenarios show the exact cycle counts: the synchroniser latency, the length of the drive interval and the one-cycle gaps around acknowledge. They also cover every one of the 2048 pin-mode combinations and the different ways a wait-stretched cycle ends.

// File: rtl/busrel_pkg.sv
package busrel_pkg;

    localparam int NGRP = 11;

    // pin group bit positions
    localparam int G_AD   = 0;
    localparam int G_ALO  = 1;
    localparam int G_AHI  = 2;
    localparam int G_RD   = 3;
    localparam int G_WR   = 4;
    localparam int G_HWR  = 5;
    localparam int G_RW   = 6;
    localparam int G_RAS  = 7;
    localparam int G_CS0  = 8;
    localparam int G_CS1  = 9;
    localparam int G_CS2  = 10;

    localparam logic [NGRP-1:0] STROBE_MASK =
        (NGRP'(1) << G_RD) | (NGRP'(1) << G_WR) | (NGRP'(1) << G_HWR) |
        (NGRP'(1) << G_RW) | (NGRP'(1) << G_RAS);

    localparam logic [NGRP-1:0] PULLUP_MASK =
        (NGRP'(1) << G_AHI) | (NGRP'(1) << G_HWR) | (NGRP'(1) << G_RW) |
        (NGRP'(1) << G_RAS) | (NGRP'(1) << G_CS0) | (NGRP'(1) << G_CS1) |
        (NGRP'(1) << G_CS2);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_END,
        ST_DRIVE_INACT,
        ST_FLOATED,
        ST_RESTORE
    } rel_state_t;

endpackage

// File: rtl/busrel_sync.sv
module busrel_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/busrel_fsm.sv
module busrel_fsm
    import busrel_pkg::*;
#(
    parameter int DRIVE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       wait_n,
    input  logic       cycle_active,
    output rel_state_t state,
    output logic       bus_ack_n,
    output logic       core_stall
);
    localparam int CW = $clog2(DRIVE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DRIVE_CYCLES - 1);

    rel_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic ack_n_q;
    logic busy_cycle;
    logic cnt_done;

    assign busy_cycle = cycle_active || !wait_n;
    assign cnt_done   = (cnt_q == CNT_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = busy_cycle ? ST_WAIT_END : ST_DRIVE_INACT;
            end
            ST_WAIT_END: begin
                if (!req)            state_d = ST_IDLE;
                else if (!busy_cycle) state_d = ST_DRIVE_INACT;
            end
            ST_DRIVE_INACT: begin
                if (cnt_done) state_d = ST_FLOATED;
            end
            ST_FLOATED: begin
                if (!req && ack_n_q) state_d = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (cnt_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, interval counter and acknowledge register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ack_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_DRIVE_INACT || state_q == ST_RESTORE) && !cnt_done)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
            ack_n_q <= !(state_q == ST_FLOATED && req);
        end
    end

    assign state      = state_q;
    assign bus_ack_n  = ack_n_q;
    assign core_stall = (state_q != ST_IDLE);

    assert_ack_only_floated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_q |-> state_q == ST_FLOATED);

    assert_ack_fall_after_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n_q) |-> $past(state_q) == ST_FLOATED);

    assert_restore_needs_ack_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RESTORE |-> ack_n_q);

    assert_wait_not_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_END && busy_cycle) |=> (state_q == ST_WAIT_END || state_q == ST_IDLE));

    assert_counter_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(DRIVE_CYCLES));
endmodule

// File: rtl/busrel_pinctl.sv
module busrel_pinctl
    import busrel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  rel_state_t      state,
    input  logic [NGRP-1:0] grp_bus,
    input  logic            cs2_pd_cfg,
    output logic [NGRP-1:0] grp_float,
    output logic [NGRP-1:0] grp_force_hi,
    output logic [NGRP-1:0] grp_pull_up,
    output logic            cs2_pull_dn
);
    logic in_drive;
    logic in_float;

    assign in_drive = (state == ST_DRIVE_INACT) || (state == ST_RESTORE);
    assign in_float = (state == ST_FLOATED);

    for (genvar g = 0; g < NGRP; g++) begin : g_pin
        localparam bit IS_STROBE = STROBE_MASK[g];
        localparam bit HAS_PU    = PULLUP_MASK[g];
        assign grp_float[g]    = grp_bus[g] && in_float;
        if (IS_STROBE) begin : g_strobe
            assign grp_force_hi[g] = grp_bus[g] && in_drive;
        end else begin : g_plain
            assign grp_force_hi[g] = 1'b0;
        end
        if (HAS_PU) begin : g_pu
            assign grp_pull_up[g] = grp_bus[g] && in_float;
        end else begin : g_nopu
            assign grp_pull_up[g] = 1'b0;
        end
    end

    assign cs2_pull_dn = cs2_pd_cfg && !grp_pull_up[G_CS2];

    assert_float_force_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_float & grp_force_hi) == '0);

    assert_port_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_float | grp_force_hi | grp_pull_up) & ~grp_bus) == '0);

    assert_cs2_pulls_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs2_pull_dn && grp_pull_up[G_CS2]));
endmodule

// File: rtl/busrel_arbiter.sv
module busrel_arbiter
    import busrel_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DRIVE_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req_n,
    input  logic            wait_n,
    input  logic            cycle_active,
    input  logic [NGRP-1:0] grp_bus,
    input  logic            cs2_pd_cfg,
    output logic            bus_ack_n,
    output logic            core_stall,
    output logic [NGRP-1:0] grp_float,
    output logic [NGRP-1:0] grp_force_hi,
    output logic [NGRP-1:0] grp_pull_up,
    output logic            cs2_pull_dn
);
    logic       req_n_sync;
    logic       req;
    rel_state_t state;

    busrel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_req_n),
        .q_sync  (req_n_sync)
    );

    assign req = !req_n_sync;

    busrel_fsm #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .wait_n       (wait_n),
        .cycle_active (cycle_active),
        .state        (state),
        .bus_ack_n    (bus_ack_n),
        .core_stall   (core_stall)
    );

    busrel_pinctl u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .grp_bus      (grp_bus),
        .cs2_pd_cfg   (cs2_pd_cfg),
        .grp_float    (grp_float),
        .grp_force_hi (grp_force_hi),
        .grp_pull_up  (grp_pull_up),
        .cs2_pull_dn  (cs2_pull_dn)
    );

    assert_ack_implies_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack_n |-> core_stall);

    assert_ack_means_floated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ack_n && $stable(grp_bus)) |-> grp_float == grp_bus);
endmodule

// File: tb/sim_busrel_arbiter.sv
module sim_busrel_arbiter;
    localparam int CLK_P   = 10;
    localparam int BENCH_D = 2;
    localparam int NG      = 11;
    localparam logic [NG-1:0] STROBES = 11'h0F8;
    localparam logic [NG-1:0] PULLS   = 11'h7E4;

    // expected phases
    localparam int PH_IDLE  = 0;
    localparam int PH_WAIT  = 1;
    localparam int PH_DRIVE = 2;
    localparam int PH_FLOAT = 3;
    localparam int PH_ACKED = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req_n = 1'b1;
    logic wait_n = 1'b1;
    logic cycle_active = 1'b0;
    logic [NG-1:0] grp_bus = '0;
    logic cs2_pd_cfg = 1'b0;
    logic bus_ack_n, core_stall, cs2_pull_dn;
    logic [NG-1:0] grp_float, grp_force_hi, grp_pull_up;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    busrel_arbiter #(.SYNC_STAGES(2), .DRIVE_CYCLES(BENCH_D)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .wait_n(wait_n),
        .cycle_active(cycle_active), .grp_bus(grp_bus), .cs2_pd_cfg(cs2_pd_cfg),
        .bus_ack_n(bus_ack_n), .core_stall(core_stall), .grp_float(grp_float),
        .grp_force_hi(grp_force_hi), .grp_pull_up(grp_pull_up), .cs2_pull_dn(cs2_pull_dn)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_phase(input int ph, input string tag);
        logic [NG-1:0] e_float, e_force, e_pu;
        logic e_ack_n, e_stall, e_pd;
        e_float = '0; e_force = '0; e_pu = '0;
        e_ack_n = 1'b1;
        e_stall = (ph != PH_IDLE);
        if (ph == PH_DRIVE) e_force = STROBES & grp_bus;
        if (ph == PH_FLOAT || ph == PH_ACKED) begin
            e_float = grp_bus;
            e_pu    = PULLS & grp_bus;
        end
        if (ph == PH_ACKED) e_ack_n = 1'b0;
        e_pd = cs2_pd_cfg & ~e_pu[10];
        chk(tag, "bus_ack_n",    32'(bus_ack_n),    32'(e_ack_n));
        chk(tag, "core_stall",   32'(core_stall),   32'(e_stall));
        chk(tag, "grp_float",    32'(grp_float),    32'(e_float));
        chk(tag, "grp_force_hi", 32'(grp_force_hi), 32'(e_force));
        chk(tag, "grp_pull_up",  32'(grp_pull_up),  32'(e_pu));
        chk(tag, "cs2_pull_dn",  32'(cs2_pull_dn),  32'(e_pd));
    endtask

    // from the floated+acked phase: remove request and follow the hand-back
    task automatic release_seq();
        bus_req_n = 1'b1;
        tick(); expect_phase(PH_ACKED, "R1 release sync 1");
        tick(); expect_phase(PH_ACKED, "R1 release sync 2");
        tick(); expect_phase(PH_FLOAT, "R6 ack high before drivers on");
        for (int i = 0; i < BENCH_D; i++) begin
            tick(); expect_phase(PH_DRIVE, "R6 restore strobes high");
        end
        tick(); expect_phase(PH_IDLE, "R6 R7 back to idle");
    endtask

    task automatic drive_to_ack();
        for (int i = 0; i < BENCH_D; i++) begin
            tick(); expect_phase(PH_DRIVE, "R3 strobes driven inactive");
        end
        tick(); expect_phase(PH_FLOAT, "R4 R8 R9 floated before ack");
        tick(); expect_phase(PH_ACKED, "R5 ack one cycle after float");
        tick(); expect_phase(PH_ACKED, "R5 ack held");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_phase(PH_IDLE, "R11 reset state");

        // sweep every pin-mode combination through grant and return
        for (int m = 0; m < (1 << NG); m++) begin
            grp_bus    = NG'(m);
            cs2_pd_cfg = grp_bus[0] ^ grp_bus[3];
            bus_req_n  = 1'b0;
            tick(); expect_phase(PH_IDLE, "R1 sync stage 1");
            tick(); expect_phase(PH_IDLE, "R1 sync stage 2");
            drive_to_ack();
            release_seq();
        end

        // wait-stretched and in-progress cycles
        grp_bus = '1;
        cs2_pd_cfg = 1'b1;
        for (int hold = 0; hold < 4; hold++) begin
            for (int w = 0; w < 2; w++) begin
                cycle_active = 1'b1;
                wait_n = w[0];
                bus_req_n = 1'b0;
                tick(); expect_phase(PH_IDLE, "R1 sync stage 1");
                tick(); expect_phase(PH_IDLE, "R1 sync stage 2");
                tick(); expect_phase(PH_WAIT, "R2 R7 deferred by cycle");
                for (int i = 0; i < hold; i++) begin
                    tick(); expect_phase(PH_WAIT, "R2 held by wait");
                end
                wait_n = 1'b1;
                tick(); expect_phase(PH_WAIT, "R2 cycle still active");
                cycle_active = 1'b0;
                drive_to_ack();
                release_seq();
            end
        end

        // wait alone, no cycle flag
        wait_n = 1'b0;
        bus_req_n = 1'b0;
        tick(); tick();
        tick(); expect_phase(PH_WAIT, "R2 wait alone defers");
        wait_n = 1'b1;
        drive_to_ack();
        release_seq();

        // request withdrawn during the wait state
        cycle_active = 1'b1;
        bus_req_n = 1'b0;
        tick(); tick();
        tick(); expect_phase(PH_WAIT, "R10 wait state entered");
        bus_req_n = 1'b1;
        tick(); expect_phase(PH_WAIT, "R10 withdraw sync 1");
        tick(); expect_phase(PH_WAIT, "R10 withdraw sync 2");
        tick(); expect_phase(PH_IDLE, "R10 back to idle without ack");
        cycle_active = 1'b0;
        tick(); expect_phase(PH_IDLE, "R10 stays idle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule